// File: doc/BRIEF.md
# Internal RAM Window Select with Read Echo

This block decodes a 32 KB window of a 20-bit address space for an on-chip zero-wait-state RAM and sequences the processor bus cycle for that RAM. A configuration register places the window on any 32 KB boundary. Its enable bit can be switched at run time, and a second bit echoes internal read data onto the external multiplexed address/data bus so that an analyser can see it. The RAM array itself stays outside: the block drives its address and write strobe and takes its read data as an input. An external select decoder may map the same range. When it does, writes reach both devices and reads take the internal data.

Two debug pins are sampled while reset is held. One keeps the internal RAM disabled whatever the enable bit holds. The other forces read echo on. Every bus cycle runs through the address phase T1, then T2 and T3, then T4. An external access may stretch the cycle with wait states while its ready is low. An internal access never does.

Top module: `ram_sel_top`

## Requirements
- R1: The configuration register holds the window base in bits 15..11, which are compared with address bits 19..15. When the comparison matches and the RAM is enabled at the cycle start, intSel is high in every phase from T1 through T4 of that cycle, and it is low for all other cycles.
- R2: busState encodes the phase as 0 idle, 1 T1, 2 T2, 3 T3, 4 wait, 5 T4. An internal cycle always passes T1, T2, T3, T4 and ignores extReady. An external cycle enters the wait state after T3 and repeats it while extReady is low.
- R3: Bit 0 of the register enables the window. When it is cleared, no cycle asserts intSel or ramWrEn. Setting it again restores hits, and it can be toggled any number of times.
- R4: Bit 1 of the register enables read echo. During an internal read with echo active, adOe is high in T3 and adOut equals ramRdData. Without echo, or on an external read, adOe stays low from T2 through T4 of a read.
- R5: If disPinN is low at the last clock edge of reset, no cycle asserts intSel, even with bit 0 set. Bit 0 still reads back as written.
- R6: If showPinN is low at the last clock edge of reset, read echo is active even with bit 1 clear.
- R7: In every cycle adOut carries address bits 15..0 in T1 with adOe high. A write then drives wrData with adOe high in T2, T3, any wait state and T4. An internal write pulses ramWrEn once, in T4, with ramAddr equal to address bits 14..0.
- R8: rdValid pulses in T4 of each read. rdData then equals ramRdData for an internal read, regardless of extRdData, and extRdData otherwise.
- R9: After reset the register reads 0. Bits 10..2 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset; debug pins are sampled while it is low |
| disPinN | input | 1 | Debug pin; low during reset disables the internal RAM |
| showPinN | input | 1 | Debug pin; low during reset forces read echo |
| cfgWrEn | input | 1 | Configuration register write strobe |
| cfgWrData | input | 16 | Configuration write value |
| cfgRdData | output | 16 | Configuration readback |
| cycStart | input | 1 | Starts a bus cycle (accepted in idle or T4) |
| cycAddr | input | 20 | Cycle address, captured at start |
| cycWrite | input | 1 | 1 = write cycle, 0 = read cycle |
| wrData | input | 16 | Write data, captured at start |
| extReady | input | 1 | External ready, used only for external cycles |
| ramRdData | input | 16 | Read data from the RAM array |
| extRdData | input | 16 | Read data from external devices |
| busState | output | 3 | Current bus phase |
| intSel | output | 1 | Internal RAM select |
| ramAddr | output | 15 | RAM word address |
| ramWrEn | output | 1 | RAM write strobe |
| rdValid | output | 1 | Read data valid for the processor |
| rdData | output | 16 | Read data for the processor |
| adOut | output | 16 | Multiplexed address/data bus value |
| adOe | output | 1 | Multiplexed bus output enable |

## Verification
Two functions can meet in the same cycle: a window hit and an overlapping external device that answers the same read. The overlap is provoked by holding extReady low and presenting a distinct extRdData during an internal read. The bench then judges that the cycle still ends after exactly four phases and that rdValid carries the RAM value rather than the external one. Read echo and the reset-sampled force pin also coincide with a cleared show bit, and the bench checks that the T3 bus value follows the pin.

// File: rtl/rsel_pkg.sv
package rsel_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_TW   = 3'd4,
    PH_T4   = 3'd5
  } phase_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture;    // cycle accepted on this edge
    logic addrPhase;  // T1
    logic dataPhase;  // T2, T3, wait, T4
    logic latePhase;  // T3
    logic endPhase;   // T4
    logic active;     // any phase but idle
  } strobe_t;

endpackage

// File: rtl/rsel_ctrl.sv
module rsel_ctrl
  import rsel_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cycStart,
  input  logic    extReady,
  input  logic    hitQ,
  output phase_e  phase,
  output strobe_t strb
);

  phase_e phaseQ, phaseD;
  logic   canStart;

  assign canStart = (phaseQ == PH_IDLE) || (phaseQ == PH_T4);

  always_comb begin
    phaseD = phaseQ;
    unique case (phaseQ)
      PH_IDLE: if (cycStart) phaseD = PH_T1;
      PH_T1:   phaseD = PH_T2;
      PH_T2:   phaseD = PH_T3;
      // internal cycles never wait; ready only counts outside the window
      PH_T3:   phaseD = (hitQ || extReady) ? PH_T4 : PH_TW;
      PH_TW:   phaseD = extReady ? PH_T4 : PH_TW;
      PH_T4:   phaseD = cycStart ? PH_T1 : PH_IDLE;
      default: phaseD = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phaseQ <= PH_IDLE;
    else       phaseQ <= phaseD;
  end

  always_comb begin
    strb.capture   = cycStart && canStart;
    strb.addrPhase = (phaseQ == PH_T1);
    strb.dataPhase = (phaseQ == PH_T2) || (phaseQ == PH_T3) ||
                     (phaseQ == PH_TW) || (phaseQ == PH_T4);
    strb.latePhase = (phaseQ == PH_T3);
    strb.endPhase  = (phaseQ == PH_T4);
    strb.active    = (phaseQ != PH_IDLE);
  end

  assign phase = phaseQ;

endmodule

// File: rtl/rsel_dpath.sv
module rsel_dpath
  import rsel_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 16,
  parameter int WIN_LOG2 = 15
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                disPinN,
  input  logic                showPinN,
  input  logic                cfgWrEn,
  input  logic [DATA_W-1:0]   cfgWrData,
  output logic [DATA_W-1:0]   cfgRdData,
  input  strobe_t             strb,
  input  logic [ADDR_W-1:0]   cycAddr,
  input  logic                cycWrite,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [DATA_W-1:0]   ramRdData,
  input  logic [DATA_W-1:0]   extRdData,
  output logic                hitQ,
  output logic                intSel,
  output logic [WIN_LOG2-1:0] ramAddr,
  output logic                ramWrEn,
  output logic                rdValid,
  output logic [DATA_W-1:0]   rdData,
  output logic [DATA_W-1:0]   adOut,
  output logic                adOe
);

  localparam int BASE_W = ADDR_W - WIN_LOG2;
  localparam int RSV_W  = DATA_W - BASE_W - 2;
  localparam int LAT_W  = (DATA_W > WIN_LOG2) ? DATA_W : WIN_LOG2;

  // configuration register
  logic [BASE_W-1:0] baseQ;
  logic              showBitQ, enBitQ;
  // reset-sampled debug overrides
  logic              disForcedQ, showForcedQ;
  logic              enEff, showEff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ    <= '0;
      showBitQ <= 1'b0;
      enBitQ   <= 1'b0;
    end else if (cfgWrEn) begin
      baseQ    <= cfgWrData[DATA_W-1 -: BASE_W];
      showBitQ <= cfgWrData[1];
      enBitQ   <= cfgWrData[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      disForcedQ  <= !disPinN;
      showForcedQ <= !showPinN;
    end
  end

  assign enEff   = enBitQ && !disForcedQ;
  assign showEff = showBitQ || showForcedQ;
  assign cfgRdData = {baseQ, {RSV_W{1'b0}}, showBitQ, enBitQ};

  // per-cycle capture
  logic [LAT_W-1:0]  addrQ;
  logic [DATA_W-1:0] wrDataQ;
  logic              writeQ, showQ;
  logic              hitNow;

  assign hitNow = enEff && (cycAddr[ADDR_W-1 -: BASE_W] == baseQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      wrDataQ <= '0;
      writeQ  <= 1'b0;
      hitQ    <= 1'b0;
      showQ   <= 1'b0;
    end else if (strb.capture) begin
      addrQ   <= cycAddr[LAT_W-1:0];
      wrDataQ <= wrData;
      writeQ  <= cycWrite;
      hitQ    <= hitNow;
      showQ   <= showEff;
    end
  end

  // bus-side outputs
  logic showDrive, wrDrive;

  assign showDrive = !writeQ && hitQ && showQ && strb.latePhase;
  assign wrDrive   = writeQ && strb.dataPhase;

  assign intSel  = hitQ && strb.active;
  assign ramAddr = addrQ[WIN_LOG2-1:0];
  assign ramWrEn = hitQ && writeQ && strb.endPhase;
  assign rdValid = !writeQ && strb.endPhase;
  assign rdData  = hitQ ? ramRdData : extRdData;
  assign adOe    = strb.addrPhase || wrDrive || showDrive;

  always_comb begin
    if (strb.addrPhase)  adOut = addrQ[DATA_W-1:0];
    else if (wrDrive)    adOut = wrDataQ;
    else if (showDrive)  adOut = ramRdData;
    else                 adOut = '0;
  end

endmodule

// File: rtl/ram_sel_top.sv
module ram_sel_top
  import rsel_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 16,
  parameter int WIN_LOG2 = 15
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                disPinN,
  input  logic                showPinN,
  input  logic                cfgWrEn,
  input  logic [DATA_W-1:0]   cfgWrData,
  output logic [DATA_W-1:0]   cfgRdData,
  input  logic                cycStart,
  input  logic [ADDR_W-1:0]   cycAddr,
  input  logic                cycWrite,
  input  logic [DATA_W-1:0]   wrData,
  input  logic                extReady,
  input  logic [DATA_W-1:0]   ramRdData,
  input  logic [DATA_W-1:0]   extRdData,
  output logic [2:0]          busState,
  output logic                intSel,
  output logic [WIN_LOG2-1:0] ramAddr,
  output logic                ramWrEn,
  output logic                rdValid,
  output logic [DATA_W-1:0]   rdData,
  output logic [DATA_W-1:0]   adOut,
  output logic                adOe
);

  strobe_t strb;
  phase_e  phase;
  logic    hitQ;

  rsel_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .cycStart (cycStart),
    .extReady (extReady),
    .hitQ     (hitQ),
    .phase    (phase),
    .strb     (strb)
  );

  rsel_dpath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .WIN_LOG2 (WIN_LOG2)
  ) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .disPinN   (disPinN),
    .showPinN  (showPinN),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .cfgRdData (cfgRdData),
    .strb      (strb),
    .cycAddr   (cycAddr),
    .cycWrite  (cycWrite),
    .wrData    (wrData),
    .ramRdData (ramRdData),
    .extRdData (extRdData),
    .hitQ      (hitQ),
    .intSel    (intSel),
    .ramAddr   (ramAddr),
    .ramWrEn   (ramWrEn),
    .rdValid   (rdValid),
    .rdData    (rdData),
    .adOut     (adOut),
    .adOe      (adOe)
  );

  assign busState = phase;

endmodule

// File: rtl/ram_sel_chk.sv
module ram_sel_chk #(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 16,
  parameter int WIN_LOG2 = 15
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        busState,
  input logic              intSel,
  input logic              ramWrEn,
  input logic              rdValid,
  input logic              adOe,
  input logic [DATA_W-1:0] cfgRdData
);

  localparam int BASE_W = ADDR_W - WIN_LOG2;

  // R1: select holds across all phases after T1
  a_r1_sel_holds: assert property (@(posedge clk) disable iff (!rstN)
    (intSel && busState != 3'd1) |-> $past(intSel));

  // R2: an internal cycle goes from T3 straight to T4
  a_r2_int_no_wait: assert property (@(posedge clk) disable iff (!rstN)
    (busState == 3'd3 && intSel) |=> (busState == 3'd5));

  // R2: wait states belong to external cycles only
  a_r2_wait_external: assert property (@(posedge clk) disable iff (!rstN)
    (busState == 3'd4) |-> !intSel);

  // R4: nothing is driven and nothing is selected while idle
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (busState == 3'd0) |-> (!adOe && !intSel));

  // R7: RAM write strobe only in T4 of a selected, driven write
  a_r7_wr_in_t4: assert property (@(posedge clk) disable iff (!rstN)
    ramWrEn |-> (busState == 3'd5 && intSel && adOe));

  // R8: read valid only in T4 and never with a RAM write
  a_r8_rdvalid_end: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (busState == 3'd5 && !ramWrEn));

  // R9: reserved register bits read as zero
  a_r9_rsvd_zero: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdData[DATA_W-BASE_W-1:2] == '0);

endmodule

bind ram_sel_top ram_sel_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .WIN_LOG2 (WIN_LOG2)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .busState  (busState),
  .intSel    (intSel),
  .ramWrEn   (ramWrEn),
  .rdValid   (rdValid),
  .adOe      (adOe),
  .cfgRdData (cfgRdData)
);

// File: tb/ram_sel_top_tb_top.sv
`timescale 1ns/1ps
module ram_sel_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN, disPinN, showPinN, cfgWrEn, cycStart, cycWrite, extReady;
  logic [15:0] cfgWrData, cfgRdData, wrData, ramRdData, extRdData, rdData, adOut;
  logic [19:0] cycAddr;
  logic [2:0]  busState;
  logic        intSel, ramWrEn, rdValid, adOe;
  logic [14:0] ramAddr;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ram_sel_top dut_i (
    .clk(clk), .rstN(rstN), .disPinN(disPinN), .showPinN(showPinN),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .cycStart(cycStart), .cycAddr(cycAddr), .cycWrite(cycWrite), .wrData(wrData),
    .extReady(extReady), .ramRdData(ramRdData), .extRdData(extRdData),
    .busState(busState), .intSel(intSel), .ramAddr(ramAddr), .ramWrEn(ramWrEn),
    .rdValid(rdValid), .rdData(rdData), .adOut(adOut), .adOe(adOe)
  );

  // observations of the last cycle
  int          nCyc, nTw, wrCnt, rvCnt;
  bit          selAll, selAny, t1Oe, t3Oe, wrOk, rdOeBad;
  logic [15:0] t1Addr, t3Out, rvData;
  logic [14:0] wrAddr;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic doReset(input bit disLvl, input bit showLvl);
    rstN = 1'b0; disPinN = disLvl; showPinN = showLvl;
    cfgWrEn = 0; cfgWrData = '0; cycStart = 0; cycAddr = '0; cycWrite = 0;
    wrData = '0; extReady = 0; ramRdData = '0; extRdData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    disPinN = 1'b1; showPinN = 1'b1; // pins are ignored after reset
  endtask

  task automatic writeCfg(input logic [15:0] v);
    @(negedge clk); cfgWrEn = 1; cfgWrData = v;
    @(negedge clk); cfgWrEn = 0;
  endtask

  function automatic logic [15:0] cfgVal(input logic [4:0] base, input bit show, input bit en);
    return {base, 9'd0, show, en};
  endfunction

  task automatic runCycle(input logic [19:0] a, input bit wr, input logic [15:0] wd,
                          input logic [15:0] rd, input logic [15:0] xd, input int nWait);
    @(negedge clk);
    cycAddr = a; cycWrite = wr; wrData = wd; ramRdData = rd; extRdData = xd;
    extReady = 0; cycStart = 1;
    @(negedge clk);
    cycStart = 0;
    nCyc = 0; nTw = 0; wrCnt = 0; rvCnt = 0; selAll = 1; selAny = 0;
    t1Oe = 0; t3Oe = 0; wrOk = 1; rdOeBad = 0; t1Addr = '0; t3Out = '0;
    rvData = '0; wrAddr = '0;
    for (int i = 0; i < 20; i++) begin
      if (busState == 3'd0) break;
      nCyc++;
      if (intSel) selAny = 1; else selAll = 0;
      if (busState == 3'd1) begin t1Addr = adOut; t1Oe = adOe; end
      if (busState == 3'd3) begin t3Oe = adOe; t3Out = adOut; end
      if (busState == 3'd4) nTw++;
      if (wr && busState != 3'd1 && !(adOe && adOut == wd)) wrOk = 0;
      if (!wr && busState != 3'd1 && busState != 3'd3 && adOe) rdOeBad = 1;
      if (ramWrEn) begin wrCnt++; wrAddr = ramAddr; end
      if (rdValid) begin rvCnt++; rvData = rdData; end
      extReady = (busState == 3'd3 || busState == 3'd4) ? (nTw >= nWait) : 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic testResetState();
    doReset(1, 1);
    chk(cfgRdData == 16'h0, "R9", "cfg after reset", cfgRdData, 0);
    chk(!intSel && !adOe && busState == 0, "R9", "idle outputs", {intSel, adOe, busState}, 0);
    writeCfg(16'hFFFF);
    chk(cfgRdData == 16'hF803, "R9", "reserved bits read zero", cfgRdData, 16'hF803);
  endtask

  task automatic testWindow();
    writeCfg(cfgVal(5'd1, 0, 1));
    runCycle(20'h08123, 0, 0, 16'h1111, 16'h2222, 0);
    chk(selAll && nCyc == 4, "R1", "hit inside window", {selAll, nCyc[7:0]}, {1'b1, 8'd4});
    runCycle(20'h0FFFF, 0, 0, 16'h1111, 16'h2222, 0);
    chk(selAll, "R1", "top of window hits", selAll, 1);
    runCycle(20'h07FFF, 0, 0, 16'h1111, 16'h2222, 0);
    chk(!selAny, "R1", "below window misses", selAny, 0);
    runCycle(20'h10000, 0, 0, 16'h1111, 16'h2222, 0);
    chk(!selAny, "R1", "above window misses", selAny, 0);
  endtask

  task automatic testWaits();
    runCycle(20'h08010, 0, 0, 16'hAAAA, 16'h5555, 100);
    chk(nCyc == 4 && nTw == 0, "R2", "internal ignores ready", nCyc, 4);
    runCycle(20'h30010, 0, 0, 16'hAAAA, 16'h5555, 2);
    chk(nTw == 2 && nCyc == 6, "R2", "external wait states", nTw, 2);
  endtask

  task automatic testEnable();
    writeCfg(cfgVal(5'd1, 0, 0));
    runCycle(20'h08020, 1, 16'hBEEF, 0, 0, 0);
    chk(!selAny && wrCnt == 0, "R3", "disabled: no select no write", {selAny, wrCnt[7:0]}, 0);
    writeCfg(cfgVal(5'd1, 0, 1));
    runCycle(20'h08020, 0, 0, 16'h1234, 0, 0);
    chk(selAll, "R3", "re-enabled hit", selAll, 1);
    writeCfg(cfgVal(5'd1, 0, 0));
    writeCfg(cfgVal(5'd1, 0, 1));
    runCycle(20'h08020, 0, 0, 16'h1234, 0, 0);
    chk(selAll, "R3", "second toggle hit", selAll, 1);
  endtask

  task automatic testShow();
    writeCfg(cfgVal(5'd2, 0, 1));
    runCycle(20'h10044, 0, 0, 16'hC0DE, 16'h0BAD, 0);
    chk(!t3Oe && !rdOeBad, "R4", "no echo when off", t3Oe, 0);
    writeCfg(cfgVal(5'd2, 1, 1));
    runCycle(20'h10044, 0, 0, 16'hC0DE, 16'h0BAD, 0);
    chk(t3Oe && t3Out == 16'hC0DE, "R4", "echo in T3", t3Out, 16'hC0DE);
    chk(!rdOeBad, "R4", "echo only in T3", rdOeBad, 0);
    runCycle(20'h50044, 0, 0, 16'hC0DE, 16'h0BAD, 0);
    chk(!t3Oe && !rdOeBad, "R4", "no echo on external read", t3Oe, 0);
  endtask

  task automatic testWrite();
    writeCfg(cfgVal(5'd3, 0, 1));
    runCycle(20'h1ABCD, 1, 16'hFACE, 0, 0, 0);
    chk(t1Oe && t1Addr == 16'hABCD, "R7", "address in T1", t1Addr, 16'hABCD);
    chk(wrOk, "R7", "write data T2..T4", wrOk, 1);
    chk(wrCnt == 1 && wrAddr == 15'h2BCD, "R7", "RAM write strobe", wrAddr, 15'h2BCD);
    runCycle(20'h6ABCD, 1, 16'h7777, 0, 0, 1);
    chk(wrOk && t1Addr == 16'hABCD && wrCnt == 0, "R7", "external write bus", wrCnt, 0);
  endtask

  task automatic testReadData();
    writeCfg(cfgVal(5'd3, 0, 1));
    runCycle(20'h18000, 0, 0, 16'h4321, 16'h9999, 100);
    chk(rvCnt == 1 && rvData == 16'h4321, "R8", "overlap read takes internal", rvData, 16'h4321);
    runCycle(20'h28000, 0, 0, 16'h4321, 16'h9999, 0);
    chk(rvCnt == 1 && rvData == 16'h9999, "R8", "external read data", rvData, 16'h9999);
  endtask

  task automatic testDisablePin();
    doReset(0, 1);
    writeCfg(cfgVal(5'd0, 0, 1));
    chk(cfgRdData == 16'h0001, "R5", "enable bit reads back", cfgRdData, 1);
    runCycle(20'h00100, 1, 16'h1357, 0, 0, 0);
    chk(!selAny && wrCnt == 0, "R5", "pin keeps RAM off", selAny, 0);
  endtask

  task automatic testShowPin();
    doReset(1, 0);
    writeCfg(cfgVal(5'd0, 0, 1));
    runCycle(20'h00200, 0, 0, 16'h6789, 16'h0, 0);
    chk(t3Oe && t3Out == 16'h6789, "R6", "pin forces echo", t3Out, 16'h6789);
    doReset(1, 1);
    writeCfg(cfgVal(5'd0, 0, 1));
    runCycle(20'h00200, 0, 0, 16'h6789, 16'h0, 0);
    chk(!t3Oe, "R6", "no force without pin", t3Oe, 0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    testResetState();
    testWindow();
    testWaits();
    testEnable();
    testShow();
    testWrite();
    testReadData();
    testDisablePin();
    testShowPin();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule